// File: doc/BRIEF.md
# Indexed Vector Gather-Scatter Unit

This unit runs indexed vector memory operations for a vector pipeline. A gather fetches one word per element from the address given by a base plus that element's index-vector entry, and lays the fetched words into a destination vector register in dense element order. A scatter does the reverse: it takes source vector element i and stores it at the address formed from index entry i, which turns a compressed vector back into its full layout.

The unit learns each element's memory bank only once it has read that element's index. So it issues one request per element, in element order. Each bank keeps its own busy down-counter, and a request whose bank is still busy waits until the bank frees. The unit reads the index and source registers through a shared combinational read port addressed by element number. The memory side has no back-pressure. It returns read data in request order after a fixed latency. The unit pairs each return with an element by counting the returns.

Top module: `vgs_unit`

## Requirements
- R1: `cmd_ready_o` is high only while the unit is idle, which includes reset. A command is taken on a cycle with `cmd_valid_i` and `cmd_ready_o` both high. `cmd_op_i` = 0 selects gather and 1 selects scatter.
- R2: The byte address of element i is `cmd_base_i` plus index entry i, zero-extended and multiplied by 8.
- R3: A gather writes the i-th returned word to destination element i, in the same cycle as `mem_rvalid_i`.
- R4: A scatter drives `mem_we_o` = 1 with source element i on `mem_wdata_o`. A gather drives `mem_we_o` = 0.
- R5: The unit makes exactly one request per element, in rising element order. When a scatter has duplicate indices, the highest-numbered element is the value left in memory.
- R6: The bank is address bits [5:3], giving 8 banks. After a request, that bank takes no other request for the next 5 cycles. A request goes out in the first cycle that is both after the previous request and free for its bank.
- R7: `done_o` pulses for one cycle. For a scatter it comes in the cycle after the last request. For a gather it comes in the cycle after the last destination write.
- R8: A command of length 0 makes no request. It raises `done_o` in the cycle after the handshake.
- R9: Vector lengths up to 64 are supported. A 64-element command completes all 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Unit idle, command can be taken |
| cmd_op_i | input | 1 | 0 gather, 1 scatter |
| cmd_base_i | input | 32 | Base byte address |
| cmd_len_i | input | 7 | Vector length, 0 to 64 |
| vr_idx_o | output | 6 | Element number for the register read port |
| idx_data_i | input | 16 | Index entry of element `vr_idx_o` |
| src_data_i | input | 64 | Source element `vr_idx_o` (scatter) |
| dst_we_o | output | 1 | Destination register write |
| dst_idx_o | output | 6 | Destination element number |
| dst_data_o | output | 64 | Destination element data |
| mem_req_o | output | 1 | Memory request, always accepted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rvalid_i | input | 1 | Read data return, in request order |
| mem_rdata_i | input | 64 | Returned read data |
| done_o | output | 1 | Command complete pulse |

## Verification
The bench keeps its own bank-free model, and that model carries across commands. It predicts the exact cycle of every request. Because of this, a timer that freed a bank one cycle early or late, or that forgot the busy bank left over from the previous command, would show up as a wrong issue cycle. Indices that all map to one bank force back-to-back stalls. A scatter with all indices equal, read back by a gather, exposes a unit that reordered elements or dropped the last write. Zero-length commands and 64-element commands test the two length limits: a length counter that wraps at 64 or issues for length 0 would produce extra or missing requests and a misplaced done pulse.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} vgs_state_e;
  typedef enum logic {OP_GATHER = 1'b0, OP_SCATTER = 1'b1} vgs_op_e;
endpackage

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int SH = 3,
  parameter int BW = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bank_o
);
  assign addr_o = base_i + (AW'(idx_i) << SH);
  assign bank_o = addr_o[SH +: BW];
endmodule

// File: rtl/vgs_bank_timer.sv
module vgs_bank_timer #(
  parameter int NBANK    = 8,
  parameter int BUSY_CYC = 6,
  localparam int BW = $clog2(NBANK),
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [BW-1:0]    issue_bank_i,
  output logic [NBANK-1:0] free_o
);
  logic [CW-1:0] cnt_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cnt_q[b] <= '0;
      else if (issue_i && issue_bank_i == BW'(b))  cnt_q[b] <= CW'(BUSY_CYC - 1);
      else if (cnt_q[b] != '0)                     cnt_q[b] <= cnt_q[b] - CW'(1);
    end
    assign free_o[b] = (cnt_q[b] == '0);

    a_r6_busy_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && issue_bank_i == BW'(b)) |=> !free_o[b]);
  end

  a_r6_issue_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> free_o[issue_bank_i]);
endmodule

// File: rtl/vgs_unit.sv
module vgs_unit
  import vgs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int IW         = 16,
  parameter int MAXVL      = 64,
  parameter int NBANK      = 8,
  parameter int ELEM_BYTES = 8,
  parameter int BUSY_CYC   = 6,
  localparam int EW = $clog2(MAXVL),
  localparam int LW = EW + 1,
  localparam int BW = $clog2(NBANK),
  localparam int SH = $clog2(ELEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_op_i,
  input  logic [AW-1:0] cmd_base_i,
  input  logic [LW-1:0] cmd_len_i,
  output logic [EW-1:0] vr_idx_o,
  input  logic [IW-1:0] idx_data_i,
  input  logic [DW-1:0] src_data_i,
  output logic          dst_we_o,
  output logic [EW-1:0] dst_idx_o,
  output logic [DW-1:0] dst_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o
);
  vgs_state_e       state_q;
  vgs_op_e          op_q;
  logic [AW-1:0]    base_q;
  logic [LW-1:0]    len_q, elem_q, ret_q;
  logic             done_q;
  logic [BW-1:0]    bank;
  logic [NBANK-1:0] bank_free;
  logic             issue, ret;

  vgs_addr_gen #(.AW(AW), .IW(IW), .SH(SH), .BW(BW)) u_addr (
    .base_i(base_q), .idx_i(idx_data_i), .addr_o(mem_addr_o), .bank_o(bank)
  );

  vgs_bank_timer #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC)) u_timer (
    .clk_i, .rst_ni, .issue_i(issue), .issue_bank_i(bank), .free_o(bank_free)
  );

  assign issue       = (state_q == ST_ISSUE) && bank_free[bank];
  assign ret         = mem_rvalid_i && (state_q != ST_IDLE) && (op_q == OP_GATHER);
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign vr_idx_o    = elem_q[EW-1:0];
  assign mem_req_o   = issue;
  assign mem_we_o    = (op_q == OP_SCATTER);
  assign mem_wdata_o = src_data_i;
  assign dst_we_o    = ret;
  assign dst_idx_o   = ret_q[EW-1:0];
  assign dst_data_o  = mem_rdata_i;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_GATHER;
      base_q  <= '0;
      len_q   <= '0;
      elem_q  <= '0;
      ret_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_q   <= vgs_op_e'(cmd_op_i);
          base_q <= cmd_base_i;
          len_q  <= cmd_len_i;
          elem_q <= '0;
          ret_q  <= '0;
          if (cmd_len_i == '0) done_q  <= 1'b1;
          else                 state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (issue) begin
          elem_q <= elem_q + LW'(1);
          if (elem_q == len_q - LW'(1)) begin
            if (op_q == OP_SCATTER) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
      // returns can overlap issue; the last one always follows the last issue
      if (ret) begin
        ret_q <= ret_q + LW'(1);
        if (ret_q == len_q - LW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  a_r1_req_not_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cmd_ready_o);
  a_r8_zero_len_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_len_i == '0) |=> (done_o && !mem_req_o));
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
  a_r5_elem_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (vr_idx_o == EW'($past(vr_idx_o) + EW'(1))));
  a_r4_no_write_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> !(mem_req_o && mem_we_o));
endmodule

// File: tb/sim_vgs_unit.sv
`timescale 1ns/1ps
module sim_vgs_unit;
  localparam int AW = 32, DW = 64, IW = 16, EW = 6, LW = 7, LAT = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cmd_valid, cmd_ready, cmd_op;
  logic [AW-1:0] cmd_base;
  logic [LW-1:0] cmd_len;
  logic [EW-1:0] vr_idx, dst_idx;
  logic [IW-1:0] idx_data;
  logic [DW-1:0] src_data, dst_data, mem_wdata, mem_rdata;
  logic          dst_we, mem_req, mem_we, mem_rvalid, done;
  logic [AW-1:0] mem_addr;

  vgs_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_base_i(cmd_base), .cmd_len_i(cmd_len),
    .vr_idx_o(vr_idx), .idx_data_i(idx_data), .src_data_i(src_data),
    .dst_we_o(dst_we), .dst_idx_o(dst_idx), .dst_data_o(dst_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [IW-1:0] idx_vr [64];
  logic [DW-1:0] src_vr [64];
  assign idx_data = idx_vr[vr_idx];
  assign src_data = src_vr[vr_idx];

  // memory model: fixed read latency, in-order returns
  logic [DW-1:0] mem_m [1024];
  logic [DW-1:0] ref_m [1024];
  logic [LAT-1:0] pv;
  logic [DW-1:0] pd [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else begin
      pv    <= {pv[LAT-2:0], mem_req & ~mem_we};
      pd[0] <= mem_m[mem_addr[12:3]];
      for (int k = 1; k < LAT; k++) pd[k] <= pd[k-1];
      if (mem_req && mem_we) mem_m[mem_addr[12:3]] <= mem_wdata;
    end
  end
  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = pd[LAT-1];

  int n_chk = 0, n_err = 0;
  bit fin = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // scoreboard queues
  int            q_ic[$];
  logic [AW-1:0] q_ia[$];
  bit            q_iw[$];
  logic [DW-1:0] q_id[$];
  int            q_dc[$];
  int            q_di[$];
  logic [DW-1:0] q_dd[$];
  int            q_done[$];
  string         q_dtag[$];
  int            bfree[8];

  int ec, ei;
  logic [AW-1:0] ea;
  bit ew;
  logic [DW-1:0] ed;
  string et;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (mem_req) begin
        if (q_ic.size() == 0) chk(0, "R5", "unexpected request", 64'(mem_addr), 0);
        else begin
          ec = q_ic.pop_front(); ea = q_ia.pop_front();
          ew = q_iw.pop_front(); ed = q_id.pop_front();
          chk(cyc == ec, "R6", "issue cycle", 64'(cyc), 64'(ec));
          chk(mem_addr == ea, "R2", "address", 64'(mem_addr), 64'(ea));
          chk(mem_we == ew, "R4", "write enable", 64'(mem_we), 64'(ew));
          if (ew) chk(mem_wdata == ed, "R4", "write data", mem_wdata, ed);
        end
      end
      if (dst_we) begin
        if (q_dc.size() == 0) chk(0, "R3", "unexpected dst write", 64'(dst_idx), 0);
        else begin
          ec = q_dc.pop_front(); ei = q_di.pop_front(); ed = q_dd.pop_front();
          chk(cyc == ec, "R3", "dst write cycle", 64'(cyc), 64'(ec));
          chk(dst_idx == EW'(ei), "R3", "dst element", 64'(dst_idx), 64'(ei));
          chk(dst_data == ed, "R3", "dst data", dst_data, ed);
        end
      end
      if (done) begin
        if (q_done.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          ec = q_done.pop_front(); et = q_dtag.pop_front();
          chk(cyc == ec, et, "done cycle", 64'(cyc), 64'(ec));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !fin) begin
      chk(0, "R7", "watchdog expired", 64'(cyc), 0);
      report();
    end
  end

  task automatic run_cmd(input bit op, input logic [AW-1:0] base, input int len,
                         input string dtag);
    int c, t, b;
    logic [AW-1:0] a;
    while (!cmd_ready) @(negedge clk);
    c = cyc;
    cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_len = LW'(len);
    t = c;
    for (int i = 0; i < len; i++) begin
      a = base + AW'(idx_vr[i]) * 8;
      b = int'(a[5:3]);
      t = (t + 1 > bfree[b]) ? t + 1 : bfree[b];
      bfree[b] = t + 6;
      q_ic.push_back(t); q_ia.push_back(a); q_iw.push_back(op); q_id.push_back(src_vr[i]);
      if (op) ref_m[a[12:3]] = src_vr[i];
      else begin
        q_dc.push_back(t + LAT); q_di.push_back(i); q_dd.push_back(ref_m[a[12:3]]);
      end
    end
    q_done.push_back(len == 0 ? c + 1 : (op ? t + 1 : t + LAT + 1));
    q_dtag.push_back(dtag);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (len > 0) chk(!cmd_ready, "R1", "ready while busy", 64'(cmd_ready), 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_base = '0; cmd_len = '0;
    for (int i = 0; i < 1024; i++) begin
      mem_m[i] = {32'hC0DE_0000 | 32'(i), 32'(i * 7)};
      ref_m[i] = mem_m[i];
    end
    for (int i = 0; i < 64; i++) begin idx_vr[i] = '0; src_vr[i] = '0; end
    for (int i = 0; i < 8; i++) bfree[i] = 0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready in reset", 64'(cmd_ready), 1);
    chk(mem_req == 1'b0, "R1", "req in reset", 64'(mem_req), 0);
    chk(done == 1'b0, "R7", "done in reset", 64'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // distinct banks, no stall
    for (int i = 0; i < 64; i++) idx_vr[i] = IW'(i);
    run_cmd(1'b0, 32'h100, 8, "R7");
    // all in one bank, stall on each
    for (int i = 0; i < 64; i++) idx_vr[i] = IW'(i * 8);
    run_cmd(1'b0, 32'h40, 6, "R7");
    // scatter then gather back
    for (int i = 0; i < 64; i++) begin
      idx_vr[i] = IW'((i * 5) % 17);
      src_vr[i] = 64'hDEAD_0000_0000_0000 + 64'(i);
    end
    run_cmd(1'b1, 32'h200, 10, "R7");
    run_cmd(1'b0, 32'h200, 10, "R4");
    // duplicate indices, last element wins
    for (int i = 0; i < 64; i++) begin
      idx_vr[i] = IW'(5);
      src_vr[i] = 64'hBEEF_0000_0000_0000 + 64'(i);
    end
    run_cmd(1'b1, 32'h300, 4, "R5");
    run_cmd(1'b0, 32'h300, 2, "R5");
    // zero length, back to back
    run_cmd(1'b0, 32'h0, 0, "R8");
    run_cmd(1'b1, 32'h0, 0, "R8");
    // full length scatter in one bank, then gather right after
    for (int i = 0; i < 64; i++) begin
      idx_vr[i] = IW'(i * 8);
      src_vr[i] = 64'h5A5A_0000_0000_0000 + 64'(i * 3);
    end
    run_cmd(1'b1, 32'h400, 64, "R9");
    for (int i = 0; i < 64; i++) idx_vr[i] = IW'((i * 37) % 200);
    run_cmd(1'b0, 32'h0, 64, "R9");
    for (int i = 0; i < 64; i++) idx_vr[i] = IW'(i * 8);
    run_cmd(1'b0, 32'h400, 64, "R9");

    repeat (4) @(negedge clk);
    chk(q_ic.size() == 0, "R5", "requests missing", 64'(q_ic.size()), 0);
    chk(q_dc.size() == 0, "R3", "dst writes missing", 64'(q_dc.size()), 0);
    chk(q_done.size() == 0, "R7", "done missing", 64'(q_done.size()), 0);
    report();
  end
endmodule